// File: doc/BRIEF.md
# Transmit DMA Channel Credit and Error Tracker

This block holds the control and status state for eight transmit DMA channels. Each channel has a configuration word that sets its run mode and a credit-enable bit. Each channel also has one activation slot that holds a frame of transfers, and a credit counter kept against a downstream transmit FIFO. A channel issues at most one transfer per cycle. It does so only when its mode allows it, its credit-enable bit is set, its slot holds a frame and its credit is above zero.

A shared status word reports, for each channel, whether its slot is empty and whether it has no request pending. A channel is idle when both flags are set. A shared error word holds sticky flags for four kinds of fault: internal address errors, short host transfers, activation commands that reach an occupied slot, and FIFO-full reports that arrive while credit is still outstanding. Software clears each error flag by writing 1 to its bit.

An activation command carries a length field equal to the number of transfers minus one. The FIFO pops one entry per `fifo_pop` pulse, and each pop returns one credit.

Top module: `txdma_credit_tracker`

## Requirements
- R1: A configuration write to channel `cfg_ch` stores bits 31:30 (run mode) and bit 3 (credit enable) of `cfg_wdata`. Reading channel `cfg_rd_ch` returns those fields in the same positions, with every other bit 0. All channels read 0 after reset.
- R2: Run mode 2'b10 lets a channel issue. Modes 2'b00 and 2'b11 stop it. Mode 2'b01 (pause at end of frame) lets a channel issue only while a frame is already started, meaning at least one of its transfers has issued. A frame that has not started stays held.
- R3: `xfer_issue[c]` is high only when all of these hold: the slot of channel c is full, its mode allows issuing, its credit-enable bit is 1 and its credit is non-zero. A frame loaded with length L issues exactly L+1 transfers on L+1 issuing cycles. The slot empties at the edge that follows the last issue.
- R4: Each credit counter resets to CREDIT_INIT. It drops by 1 at every issue and rises by 1 at every `fifo_pop`, saturating at CREDIT_MAX. An issue and a pop in the same cycle leave the counter unchanged.
- R5: `tx_status` bits 31:24 are 1 for each channel whose slot is empty. Bits 23:16 are 1 for each channel with no pending request, where pending means slot full, mode allowing and credit enabled. Bits 15:0 read 0.
- R6: `act_cmd[c]` while slot c is full sets error bit 9+c and the command is dropped. On an empty slot it loads `act_len` and the slot becomes full.
- R7: `fifo_full[c]` while the credit of channel c is non-zero sets error bit c.
- R8: `err_addr_ev` sets error bit 31 and `err_short_ev` sets error bit 30.
- R9: Error bits are sticky. A write with `err_clr_we` clears exactly the bits set in `err_clr_data`. A new event on a bit wins over a clear of that bit in the same cycle. Bits 29:17 and 8 read 0.
- R10: In mode 2'b01, a channel whose started frame issues its last transfer reports both idle flags set from the next cycle on, and it issues nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel written |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rd_ch | input | 3 | Channel read back |
| cfg_rdata | output | 32 | Configuration read data |
| act_cmd | input | 8 | Per-channel activation command |
| act_len | input | LEN_W | Transfers in the frame, minus one |
| fifo_pop | input | 8 | Per-channel FIFO pop, returns one credit |
| fifo_full | input | 8 | Per-channel FIFO full report |
| xfer_issue | output | 8 | Per-channel transfer issued this cycle |
| err_addr_ev | input | 1 | Internal address error event |
| err_short_ev | input | 1 | Short host transfer event |
| err_clr_we | input | 1 | Error clear write strobe |
| err_clr_data | input | 32 | Error clear mask, 1 clears |
| tx_status | output | 32 | Shared empty / no-pending status |
| err_status | output | 32 | Shared sticky error flags |

## Verification
`xfer_issue`, `tx_status` and `cfg_rdata` are combinational from registered state, so they are due in the same cycle as that state. Each stimulus applied before a rising edge changes the slot, credit, configuration and error registers at that edge. The bench applies inputs after a falling edge, advances its model by one step, and then compares every output at the next falling edge, one edge after the stimulus. The directed cases use the same timing, so a frame of L+1 transfers shows issue high on exactly the L+1 sampled cycles that follow the activation edge.

// File: rtl/txdma_credit_tracker.sv
module txdma_credit_tracker #(
  parameter int CREDIT_MAX  = 8,
  parameter int CREDIT_INIT = 4,
  parameter int LEN_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_ch,
  input  logic [31:0]      cfg_wdata,
  input  logic [2:0]       cfg_rd_ch,
  output logic [31:0]      cfg_rdata,
  input  logic [7:0]       act_cmd,
  input  logic [LEN_W-1:0] act_len,
  input  logic [7:0]       fifo_pop,
  input  logic [7:0]       fifo_full,
  output logic [7:0]       xfer_issue,
  input  logic             err_addr_ev,
  input  logic             err_short_ev,
  input  logic             err_clr_we,
  input  logic [31:0]      err_clr_data,
  output logic [31:0]      tx_status,
  output logic [31:0]      err_status
);
  localparam int NCH = 8;
  localparam int CW  = $clog2(CREDIT_MAX + 1);

  logic [NCH-1:0][1:0]       mode;
  logic [NCH-1:0]            cen, slot_full, started, pend;
  logic [NCH-1:0][LEN_W-1:0] remain;
  logic [NCH-1:0][CW-1:0]    credit;
  logic [NCH-1:0]            ovr_ev, desync_ev;
  logic                      e_addr, e_short;
  logic [NCH-1:0]            e_ovr, e_desync;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic          run_ok;
    logic [CW:0]   cr_sum;

    assign run_ok       = (mode[c] == 2'b10) || (mode[c] == 2'b01 && started[c]);
    assign pend[c]      = slot_full[c] && run_ok && cen[c];
    assign xfer_issue[c] = pend[c] && (credit[c] != '0);
    assign ovr_ev[c]    = act_cmd[c] && slot_full[c];
    assign desync_ev[c] = fifo_full[c] && (credit[c] != '0);
    assign cr_sum       = {1'b0, credit[c]} + (CW+1)'(fifo_pop[c]) - (CW+1)'(xfer_issue[c]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode[c]      <= 2'b00;
        cen[c]       <= 1'b0;
        slot_full[c] <= 1'b0;
        started[c]   <= 1'b0;
        remain[c]    <= '0;
        credit[c]    <= CW'(CREDIT_INIT);
      end else begin
        if (cfg_we && cfg_ch == 3'(c)) begin
          mode[c] <= cfg_wdata[31:30];
          cen[c]  <= cfg_wdata[3];
        end
        credit[c] <= (cr_sum > (CW+1)'(CREDIT_MAX)) ? CW'(CREDIT_MAX) : cr_sum[CW-1:0];
        if (slot_full[c]) begin
          if (xfer_issue[c]) begin
            if (remain[c] == '0) begin
              slot_full[c] <= 1'b0;
              started[c]   <= 1'b0;
            end else begin
              remain[c]  <= remain[c] - 1'b1;
              started[c] <= 1'b1;
            end
          end
        end else if (act_cmd[c]) begin
          slot_full[c] <= 1'b1;
          started[c]   <= 1'b0;
          remain[c]    <= act_len;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_addr   <= 1'b0;
      e_short  <= 1'b0;
      e_ovr    <= '0;
      e_desync <= '0;
    end else begin
      e_addr   <= (e_addr   & ~(err_clr_we & err_clr_data[31])) | err_addr_ev;
      e_short  <= (e_short  & ~(err_clr_we & err_clr_data[30])) | err_short_ev;
      e_ovr    <= (e_ovr    & ~({NCH{err_clr_we}} & err_clr_data[16:9])) | ovr_ev;
      e_desync <= (e_desync & ~({NCH{err_clr_we}} & err_clr_data[7:0])) | desync_ev;
    end
  end

  assign err_status = {e_addr, e_short, 13'b0, e_ovr, 1'b0, e_desync};
  assign tx_status  = {~slot_full, ~pend, 16'b0};
  assign cfg_rdata  = {mode[cfg_rd_ch], 26'b0, cen[cfg_rd_ch], 3'b0};
endmodule

// File: rtl/txdma_credit_tracker_chk.sv
module txdma_credit_tracker_chk #(
  parameter int CREDIT_MAX = 8,
  parameter int CW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      act_cmd,
  input logic [7:0]      fifo_full,
  input logic [7:0]      xfer_issue,
  input logic [31:0]     tx_status,
  input logic [31:0]     err_status,
  input logic            err_clr_we,
  input logic            err_addr_ev,
  input logic            err_short_ev,
  input logic [8*CW-1:0] credit_flat
);
  logic [7:0] cr_nz;
  for (genvar c = 0; c < 8; c++) begin : g_nz
    assign cr_nz[c] = credit_flat[c*CW +: CW] != '0;

    a_r4_credit_bound: assert property (@(posedge clk) disable iff (!rst_n)
      credit_flat[c*CW +: CW] <= CW'(CREDIT_MAX));
  end

  a_r3_issue_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_issue & tx_status[31:24]) == 8'h00);

  a_r3_issue_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_issue & ~cr_nz) == 8'h00);

  a_r6_overrun_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|(act_cmd & ~tx_status[31:24])) |=>
      ((err_status[16:9] & $past(act_cmd & ~tx_status[31:24])) == $past(act_cmd & ~tx_status[31:24])));

  a_r7_desync_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|(fifo_full & cr_nz)) |=>
      ((err_status[7:0] & $past(fifo_full & cr_nz)) == $past(fifo_full & cr_nz)));

  a_r8_addr_latched: assert property (@(posedge clk) disable iff (!rst_n)
    err_addr_ev |=> err_status[31]);

  a_r8_short_latched: assert property (@(posedge clk) disable iff (!rst_n)
    err_short_ev |=> err_status[30]);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !err_clr_we |=> ((err_status & $past(err_status)) == $past(err_status)));
endmodule

bind txdma_credit_tracker txdma_credit_tracker_chk #(.CREDIT_MAX(CREDIT_MAX), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .act_cmd(act_cmd), .fifo_full(fifo_full),
  .xfer_issue(xfer_issue), .tx_status(tx_status), .err_status(err_status),
  .err_clr_we(err_clr_we), .err_addr_ev(err_addr_ev), .err_short_ev(err_short_ev),
  .credit_flat(credit)
);

// File: tb/tb_txdma_credit_tracker.sv
module tb_txdma_credit_tracker;
  localparam int CMAX = 8, CINIT = 4, LW = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [2:0] cfg_ch = 0; logic [31:0] cfg_wdata = 0;
  logic [2:0] cfg_rd_ch = 0; logic [31:0] cfg_rdata;
  logic [7:0] act_cmd = 0; logic [LW-1:0] act_len = 0;
  logic [7:0] fifo_pop = 0, fifo_full = 0, xfer_issue;
  logic err_addr_ev = 0, err_short_ev = 0, err_clr_we = 0;
  logic [31:0] err_clr_data = 0, tx_status, err_status;

  always #2.5 clk = ~clk;

  txdma_credit_tracker #(.CREDIT_MAX(CMAX), .CREDIT_INIT(CINIT), .LEN_W(LW)) dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [1:0] m_mode[8];
  bit m_cen[8], m_full[8], m_started[8];
  int m_rem[8], m_cr[8];
  logic [31:0] m_err;

  function automatic bit m_pend(int c);
    return m_full[c] && m_cen[c] && (m_mode[c] == 2'b10 || (m_mode[c] == 2'b01 && m_started[c]));
  endfunction
  function automatic bit m_issue(int c);
    return m_pend(c) && m_cr[c] != 0;
  endfunction
  function automatic logic [31:0] exp_status();
    logic [31:0] s = 0;
    for (int c = 0; c < 8; c++) begin
      s[24+c] = !m_full[c];
      s[16+c] = !m_pend(c);
    end
    return s;
  endfunction
  function automatic logic [31:0] exp_cfg(int c);
    return {m_mode[c], 26'b0, m_cen[c], 3'b0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 8; c++) begin
      m_mode[c] = 0; m_cen[c] = 0; m_full[c] = 0; m_started[c] = 0;
      m_rem[c] = 0; m_cr[c] = CINIT;
    end
    m_err = 0;
  endtask

  task automatic model_step();
    logic [31:0] ev = 0;
    logic [31:0] clr;
    bit iss;
    int nc;
    ev[31] = err_addr_ev; ev[30] = err_short_ev;
    for (int c = 0; c < 8; c++) begin
      iss = m_issue(c);
      if (fifo_full[c] && m_cr[c] != 0) ev[c] = 1;
      if (act_cmd[c] && m_full[c]) ev[9+c] = 1;
      nc = m_cr[c] + int'(fifo_pop[c]) - int'(iss);
      m_cr[c] = (nc > CMAX) ? CMAX : nc;
      if (m_full[c]) begin
        if (iss) begin
          if (m_rem[c] == 0) begin m_full[c] = 0; m_started[c] = 0; end
          else begin m_rem[c]--; m_started[c] = 1; end
        end
      end else if (act_cmd[c]) begin
        m_full[c] = 1; m_started[c] = 0; m_rem[c] = int'(act_len);
      end
      if (cfg_we && cfg_ch == 3'(c)) begin
        m_mode[c] = cfg_wdata[31:30]; m_cen[c] = cfg_wdata[3];
      end
    end
    clr = err_clr_we ? err_clr_data : 32'h0;
    m_err = ((m_err & ~clr) | ev) & 32'hC001_FEFF;
  endtask

  task automatic check_all();
    for (int c = 0; c < 8; c++) chk("R3 issue", 32'(xfer_issue[c]), 32'(m_issue(c)));
    chk("R5 status", tx_status, exp_status());
    chk("R9 errors", err_status, m_err);
    chk("R1 cfg readback", cfg_rdata, exp_cfg(int'(cfg_rd_ch)));
  endtask

  task automatic idle_inputs();
    cfg_we = 0; act_cmd = 0; fifo_pop = 0; fifo_full = 0;
    err_addr_ev = 0; err_short_ev = 0; err_clr_we = 0; err_clr_data = 0;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all();
    idle_inputs();
  endtask

  task automatic cfg(int c, logic [31:0] d);
    cfg_we = 1; cfg_ch = 3'(c); cfg_wdata = d; tick();
  endtask

  initial begin
    void'($urandom(32'd4217));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset cfg", cfg_rdata, 32'h0);
    chk("R5 reset status", tx_status, 32'hFFFF_0000);
    chk("R9 reset errors", err_status, 32'h0);
    chk("R3 reset issue", 32'(xfer_issue), 32'h0);

    // R1: reserved bits dropped
    cfg_rd_ch = 3'd2;
    cfg(2, 32'hFFFF_FFFF);
    chk("R1 field mask", cfg_rdata, 32'hC000_0008);
    // R2: mode 11 holds a loaded frame
    act_cmd = 8'h04; act_len = 4'd2; tick();
    chk("R2 mode 11 holds", 32'(xfer_issue), 32'h0);
    // R3: normal mode, 3 transfers, credit 4
    cfg(2, 32'h8000_0008);
    for (int i = 0; i < 3; i++) begin
      chk("R3 frame issue", 32'(xfer_issue[2]), 32'h1);
      tick();
    end
    chk("R3 frame done slot empty", 32'(tx_status[26]), 32'h1);
    // R4: one credit left; frame of 3 stalls after one issue
    act_cmd = 8'h04; act_len = 4'd2; tick();
    tick();
    chk("R4 zero credit stall", 32'(xfer_issue[2]), 32'h0);
    // R7: fifo full with zero credit is not an error, non-zero is
    fifo_full = 8'h05; tick();
    chk("R7 desync only ch0", err_status, 32'h0000_0001);
    // R6: activation into full slot
    act_cmd = 8'h04; tick();
    chk("R6 overrun ch2", err_status, 32'h0000_0801);
    // R9: clear with simultaneous new event wins
    err_clr_we = 1; err_clr_data = 32'hFFFF_FFFF; fifo_full = 8'h01; tick();
    chk("R9 set beats clear", err_status, 32'h0000_0001);
    err_clr_we = 1; err_clr_data = 32'h0000_0001; tick();
    chk("R9 w1c clear", err_status, 32'h0);
    // R8
    err_addr_ev = 1; err_short_ev = 1; tick();
    chk("R8 addr/short", err_status, 32'hC000_0000);
    err_clr_we = 1; err_clr_data = 32'h8000_0000; tick();
    chk("R9 partial clear", err_status, 32'h4000_0000);
    // R10: pause at end of frame on ch2; one credit back, frame started
    fifo_pop = 8'h04; tick();
    cfg(2, 32'h4000_0008);
    fifo_pop = 8'h04; tick();
    chk("R10 finishes started frame", 32'(xfer_issue[2]), 32'h1);
    tick();
    chk("R10 idle after eof", 32'(tx_status[26] & tx_status[18]), 32'h1);
    act_cmd = 8'h04; act_len = 4'd0; fifo_pop = 8'h04; tick();
    chk("R2 unstarted held in pause", 32'(xfer_issue[2]), 32'h0);

    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(9) == 0) begin
        cfg_we = 1; cfg_ch = 3'($urandom_range(7));
        cfg_wdata = $urandom() | (($urandom_range(4) != 0) ? 32'h8 : 32'h0);
      end
      cfg_rd_ch = 3'($urandom_range(7));
      act_cmd   = 8'($urandom() & $urandom());
      act_len   = LW'($urandom_range(5));
      fifo_pop  = 8'($urandom() & $urandom());
      fifo_full = 8'($urandom() & $urandom() & $urandom());
      err_addr_ev  = ($urandom_range(40) == 0);
      err_short_ev = ($urandom_range(40) == 0);
      err_clr_we   = ($urandom_range(6) == 0);
      err_clr_data = $urandom();
      tick();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule